// File: doc/BRIEF.md
# I2C Client Address Recognition Unit

This unit decides whether an I2C client answers the address byte that a host sends after a START or a repeated START. A bit-level shifter outside the unit presents each received address byte as an 8-bit word with a one-cycle strobe. The upper seven bits are the address and bit 0 is the read/write direction. The unit checks the address against these candidates:
- a primary address, with a per-bit don't-care mask;
- three extra addresses, each with its own enable;
- the two SMBus reserved addresses, each with its own enable.

One cycle after the strobe it reports the ACK decision, the winning candidate and the direction. When the settings ask for it, it also forwards the address byte as receive data.

The settings live in two configuration words. Word 0 holds the primary address, the mask, the enables and the mode bits. Word 1 holds the three extra addresses. A write-protect input blocks all configuration writes. A primary-address update is accepted only while client mode is off, or in the window that follows a general call (address byte 8'h00), until the next address strobe. While the client is selected, data bytes from the shifter produce a data-phase ACK or NACK and are forwarded as receive data. A STOP deselects the client.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, dec_vld_o, addr_ack_o, rw_o, rx_vld_o and data_ack_o are 0, match_idx_o is 7 (no match), and every configuration field is 0.
- R2: The primary address (word 0 bits [6:0]) matches when every received address bit whose mask bit (word 0 bits [14:8]) is 0 equals the primary bit. With a zero mask the match must be exact.
- R3: Extra address k (word 1 bits [8k+6:8k], k=0..2) matches only while its enable (word 0 bit 16+k) is 1. A disabled extra address never matches.
- R4: The SMBus default address 7'h61 (enable: word 0 bit 19) and the host header 7'h08 (enable: word 0 bit 20) are compared exactly, and only while enabled.
- R5: When several candidates match, the lowest index wins. The index is 0 for the primary address, 1..3 for the extra addresses, 4 for the default address, 5 for the host header and 7 for no match. rw_o carries bit 0 of the address byte.
- R6: dec_vld_o pulses in the cycle after addr_vld_i. In that same cycle addr_ack_o is 1 exactly when a candidate matched and sniffer mode is off.
- R7: With address-as-data (word 0 bit 21) set and sniffer mode off, a matching address byte raises rx_vld_o for one cycle and appears on rx_data_o. With it clear, or when no candidate matches, rx_vld_o stays 0.
- R8: In sniffer mode (word 0 bit 22) every address byte is forwarded on rx_data_o with rx_vld_o, whatever the address-as-data bit. addr_ack_o is then 0.
- R9: A word-0 write changes the primary address only while client_en_i is 0, or after a general call and before the next address strobe. The other fields of word 0 are written in all cases.
- R10: While wp_i is 1, writes to either configuration word have no effect.
- R11: Each data byte received while the client is selected is forwarded on rx_data_o with rx_vld_o. data_ack_o is set to 1, or to 0 when data-NACK (word 0 bit 23) is set. Data bytes received while not selected are not forwarded and give data_ack_o = 0.
- R12: A configuration write in the same cycle as an address strobe does not affect that strobe's decision. The decision uses the settings from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Configuration word select (0: control, 1: extra addresses) |
| cfg_wdata_i | input | 32 | Configuration write data |
| wp_i | input | 1 | Write protect for the configuration words |
| client_en_i | input | 1 | Client mode enabled |
| addr_vld_i | input | 1 | Address byte strobe |
| addr_byte_i | input | 8 | Address byte: address in [7:1], direction in [0] |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Received data byte |
| stop_i | input | 1 | STOP seen, deselects the client |
| dec_vld_o | output | 1 | Address decision valid, one cycle |
| addr_ack_o | output | 1 | ACK the address byte |
| match_idx_o | output | 3 | Winning candidate index |
| rw_o | output | 1 | Direction bit of the last address byte |
| rx_vld_o | output | 1 | Receive data valid, one cycle |
| rx_data_o | output | 8 | Receive data |
| data_ack_o | output | 1 | ACK value for the last data byte |

## Verification
A configuration write and an address strobe can fall in the same clock cycle, and the decision must then follow the settings from before the write. The bench drives both in one cycle, with a new primary address equal to the strobed address. It expects no match on that strobe and a match on the strobe that follows. A second collision is checked the same way: a general-call strobe in the same cycle as a primary write while client mode is on. That write must not open its own window, so it must not take effect.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  parameter int unsigned AW = 7;
  parameter int unsigned NX = 3;
  localparam int unsigned NH = NX + 3;
  localparam logic [AW-1:0] SMB_DEF_ADDR  = 7'h61;
  localparam logic [AW-1:0] SMB_HOST_ADDR = 7'h08;

  typedef enum logic [2:0] {
    IDX_PRIM = 3'd0,
    IDX_X1   = 3'd1,
    IDX_X2   = 3'd2,
    IDX_X3   = 3'd3,
    IDX_DEF  = 3'd4,
    IDX_HOST = 3'd5,
    IDX_NONE = 3'd7
  } match_idx_e;

  typedef struct packed {
    logic          nack_en;
    logic          sniff;
    logic          addr_as_data;
    logic          host_en;
    logic          def_en;
    logic [NX-1:0] x_en;
    logic [AW-1:0] mask;
    logic [AW-1:0] prim;
  } ctrl_t;
endpackage

// File: rtl/i2c_addr_cfg.sv
module i2c_addr_cfg
  import i2c_addr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   sel_i,
  input  logic [31:0]            wdata_i,
  input  logic                   wp_i,
  input  logic                   client_en_i,
  input  logic                   gc_open_i,
  output ctrl_t                  ctrl_o,
  output logic [NX-1:0][AW-1:0]  xaddr_o
);
  ctrl_t                 ctrl_q;
  logic [NX-1:0][AW-1:0] xaddr_q;
  logic                  unused_bits;

  assign unused_bits = ^{wdata_i[31:24], wdata_i[15], wdata_i[7]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      xaddr_q <= '0;
    end else if (we_i && !wp_i) begin
      if (!sel_i) begin
        ctrl_q.mask         <= wdata_i[14:8];
        ctrl_q.x_en         <= wdata_i[16 +: NX];
        ctrl_q.def_en       <= wdata_i[19];
        ctrl_q.host_en      <= wdata_i[20];
        ctrl_q.addr_as_data <= wdata_i[21];
        ctrl_q.sniff        <= wdata_i[22];
        ctrl_q.nack_en      <= wdata_i[23];
        // primary address is only writable while idle or after a general call
        if (!client_en_i || gc_open_i) ctrl_q.prim <= wdata_i[AW-1:0];
      end else begin
        for (int k = 0; k < NX; k++) xaddr_q[k] <= wdata_i[8*k +: AW];
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign xaddr_o = xaddr_q;

  // R10
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wp_i |=> $stable(ctrl_q) && $stable(xaddr_q));

  // R9
  prim_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !sel_i && client_en_i && !gc_open_i |=> $stable(ctrl_q.prim));
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_addr_pkg::*;
(
  input  ctrl_t                  ctrl_i,
  input  logic [NX-1:0][AW-1:0]  xaddr_i,
  input  logic [AW-1:0]          addr_i,
  output logic                   hit_o,
  output match_idx_e             idx_o
);
  logic [NH-1:0] hits;

  assign hits[0] = ((addr_i ^ ctrl_i.prim) & ~ctrl_i.mask) == '0;

  for (genvar k = 0; k < NX; k++) begin : g_extra
    assign hits[k+1] = ctrl_i.x_en[k] && (addr_i == xaddr_i[k]);
  end

  assign hits[NX+1] = ctrl_i.def_en  && (addr_i == SMB_DEF_ADDR);
  assign hits[NX+2] = ctrl_i.host_en && (addr_i == SMB_HOST_ADDR);

  // lowest index wins
  always_comb begin
    idx_o = IDX_NONE;
    for (int i = NH - 1; i >= 0; i--) begin
      if (hits[i]) idx_o = match_idx_e'(i[2:0]);
    end
  end

  assign hit_o = |hits;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        cfg_sel_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        wp_i,
  input  logic        client_en_i,
  input  logic        addr_vld_i,
  input  logic [7:0]  addr_byte_i,
  input  logic        data_vld_i,
  input  logic [7:0]  data_i,
  input  logic        stop_i,
  output logic        dec_vld_o,
  output logic        addr_ack_o,
  output logic [2:0]  match_idx_o,
  output logic        rw_o,
  output logic        rx_vld_o,
  output logic [7:0]  rx_data_o,
  output logic        data_ack_o
);
  ctrl_t                 ctrl;
  logic [NX-1:0][AW-1:0] xaddr;
  logic                  hit;
  match_idx_e            idx;

  logic       dec_vld_q, ack_q, rw_q, rx_vld_q, sel_q, gc_open_q, data_ack_q;
  match_idx_e idx_q;
  logic [7:0] rx_data_q;

  i2c_addr_cfg i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .sel_i       (cfg_sel_i),
    .wdata_i     (cfg_wdata_i),
    .wp_i        (wp_i),
    .client_en_i (client_en_i),
    .gc_open_i   (gc_open_q),
    .ctrl_o      (ctrl),
    .xaddr_o     (xaddr)
  );

  i2c_addr_cmp i_cmp (
    .ctrl_i  (ctrl),
    .xaddr_i (xaddr),
    .addr_i  (addr_byte_i[7:1]),
    .hit_o   (hit),
    .idx_o   (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_q  <= 1'b0;
      ack_q      <= 1'b0;
      idx_q      <= IDX_NONE;
      rw_q       <= 1'b0;
      rx_vld_q   <= 1'b0;
      rx_data_q  <= '0;
      sel_q      <= 1'b0;
      gc_open_q  <= 1'b0;
      data_ack_q <= 1'b0;
    end else begin
      dec_vld_q <= addr_vld_i;
      rx_vld_q  <= 1'b0;
      if (addr_vld_i) begin
        ack_q     <= hit && !ctrl.sniff;
        idx_q     <= idx;
        rw_q      <= addr_byte_i[0];
        sel_q     <= hit || ctrl.sniff;
        gc_open_q <= (addr_byte_i == 8'h00);
        if (ctrl.sniff || (ctrl.addr_as_data && hit)) begin
          rx_vld_q  <= 1'b1;
          rx_data_q <= addr_byte_i;
        end
      end else if (data_vld_i) begin
        data_ack_q <= sel_q && !ctrl.sniff && !ctrl.nack_en;
        if (sel_q) begin
          rx_vld_q  <= 1'b1;
          rx_data_q <= data_i;
        end
      end else if (stop_i) begin
        sel_q <= 1'b0;
      end
    end
  end

  assign dec_vld_o   = dec_vld_q;
  assign addr_ack_o  = ack_q;
  assign match_idx_o = idx_q;
  assign rw_o        = rw_q;
  assign rx_vld_o    = rx_vld_q;
  assign rx_data_o   = rx_data_q;
  assign data_ack_o  = data_ack_q;

  // R6
  dec_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_i |=> dec_vld_o);

  // R5
  ack_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_o |-> match_idx_o != IDX_NONE);

  // R8
  sniff_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_i && ctrl.sniff |=> !addr_ack_o && rx_vld_o);

  // R7
  miss_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_i && !ctrl.sniff && !hit |=> !rx_vld_o);

  // R11
  data_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_i && !addr_vld_i && ctrl.nack_en |=> !data_ack_o);
endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0, wp = 1'b0, client_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        addr_vld = 1'b0, data_vld = 1'b0, stop = 1'b0;
  logic [7:0]  addr_byte = '0, data = '0;
  logic        dec_vld, addr_ack, rw, rx_vld, data_ack;
  logic [2:0]  match_idx;
  logic [7:0]  rx_data;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .wp_i(wp), .client_en_i(client_en),
    .addr_vld_i(addr_vld), .addr_byte_i(addr_byte), .data_vld_i(data_vld),
    .data_i(data), .stop_i(stop), .dec_vld_o(dec_vld), .addr_ack_o(addr_ack),
    .match_idx_o(match_idx), .rw_o(rw), .rx_vld_o(rx_vld), .rx_data_o(rx_data),
    .data_ack_o(data_ack)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_w(logic [6:0] prim, logic [6:0] mask,
      logic [2:0] xen, logic def, logic host, logic aad, logic snf, logic nack);
    return {8'h0, nack, snf, aad, host, def, xen, 1'b0, mask, 1'b0, prim};
  endfunction

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(logic [6:0] a, logic dir);
    @(negedge clk); addr_vld = 1'b1; addr_byte = {a, dir};
    @(negedge clk); addr_vld = 1'b0;
  endtask

  task automatic send_data(logic [7:0] d);
    @(negedge clk); data_vld = 1'b1; data = d;
    @(negedge clk); data_vld = 1'b0;
  endtask

  task automatic expect_addr(string req, logic [6:0] a, logic dir, logic ack, logic [2:0] idx);
    send(a, dir);
    check({req, " dec_vld"}, dec_vld, 1'b1);
    check({req, " ack"}, addr_ack, ack);
    check({req, " idx"}, match_idx, idx);
  endtask

  task automatic t_reset;
    check("R1 dec_vld", dec_vld, 0);
    check("R1 ack", addr_ack, 0);
    check("R1 idx", match_idx, 3'd7);
    check("R1 rx_vld", rx_vld, 0);
    check("R1 data_ack", data_ack, 0);
    check("R1 rw", rw, 0);
    expect_addr("R1 zero cfg", 7'h00, 1'b0, 1'b1, 3'd0);
    expect_addr("R1 zero cfg other", 7'h2B, 1'b0, 1'b0, 3'd7);
    send(7'h2B, 1'b0); // close general-call window
  endtask

  task automatic t_primary;
    wr(0, ctrl_w(7'h3A, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    expect_addr("R2 exact", 7'h3A, 1'b1, 1'b1, 3'd0);
    expect_addr("R2 exact miss", 7'h3B, 1'b0, 1'b0, 3'd7);
    wr(0, ctrl_w(7'h3A, 7'h03, 3'b000, 0, 0, 0, 0, 0));
    expect_addr("R2 masked", 7'h39, 1'b0, 1'b1, 3'd0);
    expect_addr("R2 masked miss", 7'h3C, 1'b0, 1'b0, 3'd7);
  endtask

  task automatic t_extras;
    wr(1, {8'h0, 1'b0, 7'h33, 1'b0, 7'h22, 1'b0, 7'h11});
    wr(0, ctrl_w(7'h70, 7'h00, 3'b010, 0, 0, 0, 0, 0));
    expect_addr("R3 x2 on", 7'h22, 1'b0, 1'b1, 3'd2);
    expect_addr("R3 x1 off", 7'h11, 1'b0, 1'b0, 3'd7);
    expect_addr("R3 x3 off", 7'h33, 1'b0, 1'b0, 3'd7);
    wr(0, ctrl_w(7'h70, 7'h00, 3'b111, 0, 0, 0, 0, 0));
    expect_addr("R3 x3 on", 7'h33, 1'b0, 1'b1, 3'd3);
    expect_addr("R3 x1 on", 7'h11, 1'b0, 1'b1, 3'd1);
  endtask

  task automatic t_smbus;
    wr(0, ctrl_w(7'h70, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    expect_addr("R4 def off", 7'h61, 1'b0, 1'b0, 3'd7);
    expect_addr("R4 host off", 7'h08, 1'b0, 1'b0, 3'd7);
    wr(0, ctrl_w(7'h70, 7'h00, 3'b000, 1, 1, 0, 0, 0));
    expect_addr("R4 def on", 7'h61, 1'b0, 1'b1, 3'd4);
    expect_addr("R4 host on", 7'h08, 1'b0, 1'b1, 3'd5);
    expect_addr("R4 near miss", 7'h60, 1'b0, 1'b0, 3'd7);
  endtask

  task automatic t_priority;
    wr(1, {8'h0, 1'b0, 7'h33, 1'b0, 7'h22, 1'b0, 7'h08});
    wr(0, ctrl_w(7'h22, 7'h00, 3'b111, 1, 1, 0, 0, 0));
    expect_addr("R5 prim over x2", 7'h22, 1'b0, 1'b1, 3'd0);
    expect_addr("R5 x1 over host", 7'h08, 1'b1, 1'b1, 3'd1);
    check("R5 rw read", rw, 1'b1);
    wr(0, ctrl_w(7'h61, 7'h00, 3'b000, 1, 1, 0, 0, 0));
    expect_addr("R5 prim over def", 7'h61, 1'b0, 1'b1, 3'd0);
    check("R5 rw write", rw, 1'b0);
  endtask

  task automatic t_addr_data;
    wr(0, ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    send(7'h45, 1'b1);
    check("R7 off no rx", rx_vld, 0);
    wr(0, ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 1, 0, 0));
    send(7'h45, 1'b1);
    check("R7 on rx_vld", rx_vld, 1);
    check("R7 on rx_data", rx_data, 8'h8B);
    send(7'h46, 1'b0);
    check("R7 miss no rx", rx_vld, 0);
  endtask

  task automatic t_sniff;
    wr(0, ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 0, 1, 0));
    send(7'h12, 1'b1);
    check("R8 miss rx_vld", rx_vld, 1);
    check("R8 miss rx_data", rx_data, 8'h25);
    check("R8 miss ack", addr_ack, 0);
    send(7'h45, 1'b0);
    check("R8 hit ack", addr_ack, 0);
    check("R6 dec_vld pulse", dec_vld, 1);
    @(negedge clk);
    check("R6 dec_vld drops", dec_vld, 0);
  endtask

  task automatic t_prim_lock;
    wr(0, ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    client_en = 1'b1;
    wr(0, ctrl_w(7'h50, 7'h00, 3'b000, 0, 0, 1, 0, 0));
    expect_addr("R9 locked old", 7'h45, 1'b0, 1'b1, 3'd0);
    check("R9 other fields written", rx_vld, 1);
    expect_addr("R9 locked new", 7'h50, 1'b0, 1'b0, 3'd7);
    send(7'h00, 1'b0); // general call
    wr(0, ctrl_w(7'h50, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    expect_addr("R9 after gc new", 7'h50, 1'b0, 1'b1, 3'd0);
    wr(0, ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    expect_addr("R9 window closed", 7'h50, 1'b0, 1'b1, 3'd0);
    // general call strobe in same cycle as a primary write: write still locked
    @(negedge clk); addr_vld = 1'b1; addr_byte = 8'h00;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 0, 0, 0);
    @(negedge clk); addr_vld = 1'b0; cfg_we = 1'b0;
    expect_addr("R12 gc same cycle", 7'h45, 1'b0, 1'b0, 3'd7);
    client_en = 1'b0;
  endtask

  task automatic t_wp;
    wr(0, ctrl_w(7'h45, 7'h00, 3'b001, 0, 0, 0, 0, 0));
    wr(1, {8'h0, 1'b0, 7'h33, 1'b0, 7'h22, 1'b0, 7'h11});
    wp = 1'b1;
    wr(0, ctrl_w(7'h46, 7'h00, 3'b001, 0, 0, 0, 0, 0));
    wr(1, {8'h0, 1'b0, 7'h33, 1'b0, 7'h22, 1'b0, 7'h19});
    expect_addr("R10 prim kept", 7'h45, 1'b0, 1'b1, 3'd0);
    expect_addr("R10 prim new ignored", 7'h46, 1'b0, 1'b0, 3'd7);
    expect_addr("R10 x1 kept", 7'h11, 1'b0, 1'b1, 3'd1);
    expect_addr("R10 x1 new ignored", 7'h19, 1'b0, 1'b0, 3'd7);
    wp = 1'b0;
  endtask

  task automatic t_nack;
    wr(0, ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    send(7'h45, 1'b0);
    send_data(8'hA5);
    check("R11 ack", data_ack, 1);
    check("R11 rx_vld", rx_vld, 1);
    check("R11 rx_data", rx_data, 8'hA5);
    wr(0, ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 0, 0, 1));
    send_data(8'h3C);
    check("R11 nack", data_ack, 0);
    check("R11 nack rx_data", rx_data, 8'h3C);
    wr(0, ctrl_w(7'h45, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    send_data(8'h77);
    check("R11 unselected ack", data_ack, 0);
    check("R11 unselected rx", rx_vld, 0);
  endtask

  task automatic t_same_cycle;
    wr(0, ctrl_w(7'h40, 7'h00, 3'b000, 0, 0, 0, 0, 0));
    @(negedge clk); addr_vld = 1'b1; addr_byte = {7'h41, 1'b0};
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = ctrl_w(7'h41, 7'h00, 3'b000, 0, 0, 0, 0, 0);
    @(negedge clk); addr_vld = 1'b0; cfg_we = 1'b0;
    check("R12 old cfg ack", addr_ack, 0);
    check("R12 old cfg idx", match_idx, 3'd7);
    expect_addr("R12 new cfg next", 7'h41, 1'b0, 1'b1, 3'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_primary();
    t_extras();
    t_smbus();
    t_priority();
    t_addr_data();
    t_sniff();
    t_prim_lock();
    t_wp();
    t_nack();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule